// File: doc/BRIEF.md
# OTP Fuse Controller with Programming Key

This block is a register-mapped controller for a one-time-programmable fuse array. The array is modelled as a behavioural store: 16 banks of 8 words, each 32 bits wide. Every fuse word has a shadow word beside it. Software reaches the block through a simple single-cycle register port. It picks a word with a flat index, which is the bank times eight plus the word within the bank. It then either senses that word into its shadow or burns bits into it.

Each operation runs for a number of clock cycles taken from a timing register. A guard (relax) interval of idle cycles sits in front of the strobe pulse and another sits behind it. Programming is refused unless a 16-bit key is parked in the upper half of the control word. The key wipes itself once a burn completes. Any refused request raises a sticky error flag. Only a write through the clear alias of the control word lowers that flag.

Software can write the shadow words directly to override a value. Reading them returns the current shadow content.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, the control word (offset 0), the timing word (offset 3) and every shadow word read as zero.
- R2: The control word reads as key field [31:16], error [9], busy [8] and word index [6:0]. Its other bits read zero. A write to offset 0 loads the key and the index. A write to offset 1 ORs the written bits into them. A write to offset 2 clears the bits written as 1.
- R3: The error flag [9] is sticky. It clears only when a 1 is written to bit 9 at offset 2. Writes to offsets 0 and 1 leave it unchanged.
- R4: Writing 1 to bit 0 at offset 4 while idle starts a sense. Busy is high for read-length+1 cycles, starting with the cycle after the write. When it drops, the addressed shadow word holds the fuse word.
- R5: With guard G = relax+1 and duration T, the fuse_strobe output is high in elapsed cycle e (e = 0 is the first busy cycle) exactly when G <= e < T-G. It is never high while idle.
- R6: A write to offset 5 while idle, with the key field equal to 16'h3E77, starts a burn. Busy lasts program-length+1 cycles. At the end the fuse word becomes its old value ORed with the written data, and the key field reads zero.
- R7: A write to offset 5 without the key starts nothing, leaves the fuse word unchanged and sets the error flag.
- R8: A sense or burn request made while busy is ignored. It does not cut short the running operation, and it sets the error flag.
- R9: If bit b of fuse word 0 is set, bank b is locked. A burn request to it is refused with the error flag set, no busy phase and the key left in place.
- R10: Offsets 0x80 + index read and write the shadow words directly. Such a write does not touch the fuse array, so a later sense restores the fuse value.
- R11: The word index is bank*8 + word. A burn to bank 3 word 5 lands in shadow 0x80+29 after a sense, and the neighbouring word 28 is untouched.
- R12: The timing word at offset 3 holds program length [11:0], relax [15:12] and read length [21:16]. Bits 31:22 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 8 | Register offset; bit 7 set selects a shadow word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fuse_strobe | output | 1 | Fuse strobe pulse, framed by guard intervals |

## Verification
The checker assumes at most one register access per cycle, and that bus_wr counts only together with bus_sel. The bench drives every access for exactly one cycle at the falling edge. It never writes a shadow word in the cycle a sense completes, and it never changes the timing word during an operation. The behavioural model in the bench tracks the expected busy window and strobe window from the duration and guard it started with. It compares both on every clock, together with the register readbacks after each scenario.

// File: rtl/otpc_pkg.sv
package otpc_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

    localparam int OFF_CTRL  = 0;
    localparam int OFF_SET   = 1;
    localparam int OFF_CLR   = 2;
    localparam int OFF_TIME  = 3;
    localparam int OFF_SENSE = 4;
    localparam int OFF_DATA  = 5;

    localparam int ERR_BIT   = 9;
    localparam int LEN_W     = 13;
    localparam int GUARD_W   = 5;

    typedef struct packed {
        logic [5:0]  rd_len;
        logic [3:0]  relax;
        logic [11:0] pg_len;
    } timing_t;

    typedef enum logic {
        OP_SENSE = 1'b0,
        OP_PROG  = 1'b1
    } op_e;

    function automatic logic [LEN_W-1:0] op_span(input timing_t t, input op_e op);
        if (op == OP_PROG)
            return {1'b0, t.pg_len} + 13'd1;
        return {7'd0, t.rd_len} + 13'd1;
    endfunction

    function automatic logic [GUARD_W-1:0] op_guard(input timing_t t);
        return {1'b0, t.relax} + 5'd1;
    endfunction

endpackage

// File: rtl/otpc_seq.sv
module otpc_seq
    import otpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [LEN_W-1:0]   span_i,
    input  logic [GUARD_W-1:0] guard_i,
    output logic               busy_o,
    output logic               strobe_o,
    output logic               last_o
);

    logic [LEN_W-1:0]   elapsed_q;
    logic [LEN_W-1:0]   span_q;
    logic [GUARD_W-1:0] guard_q;
    logic [LEN_W-1:0]   guard_ext;

    assign guard_ext = {{(LEN_W-GUARD_W){1'b0}}, guard_q};
    assign last_o    = busy_o && (elapsed_q == span_q - 1'b1);
    assign strobe_o  = busy_o && (elapsed_q >= guard_ext)
                       && ((elapsed_q + guard_ext) < span_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o    <= 1'b0;
            elapsed_q <= '0;
            span_q    <= '0;
            guard_q   <= '0;
        end else if (start && !busy_o) begin
            busy_o    <= 1'b1;
            elapsed_q <= '0;
            span_q    <= span_i;
            guard_q   <= guard_i;
        end else if (busy_o) begin
            elapsed_q <= elapsed_q + 1'b1;
            if (last_o)
                busy_o <= 1'b0;
        end
    end

endmodule

// File: rtl/otpc_store.sv
module otpc_store #(
    parameter int DEPTH  = 128,
    parameter int DW     = 32,
    parameter int LOCK_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sh_we,
    input  logic [IDX_W-1:0]  sh_idx,
    input  logic [DW-1:0]     sh_wdata,
    input  logic              sense_commit,
    input  logic              prog_commit,
    input  logic [IDX_W-1:0]  op_idx,
    input  logic [DW-1:0]     prog_data,
    output logic [DW-1:0]     sh_rdata,
    output logic [LOCK_W-1:0] lock_bits
);

    logic [DW-1:0] fuse_q   [DEPTH];
    logic [DW-1:0] shadow_q [DEPTH];

    assign sh_rdata  = shadow_q[sh_idx];
    assign lock_bits = fuse_q[0][LOCK_W-1:0];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                fuse_q[i]   <= '0;
                shadow_q[i] <= '0;
            end else begin
                if (prog_commit && op_idx == IDX_W'(i))
                    fuse_q[i] <= fuse_q[i] | prog_data;
                if (sense_commit && op_idx == IDX_W'(i))
                    shadow_q[i] <= fuse_q[i];
                else if (sh_we && sh_idx == IDX_W'(i))
                    shadow_q[i] <= sh_wdata;
            end
        end
    end

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otpc_pkg::*;
#(
    parameter int BANKS   = 16,
    parameter int WORDS   = 8,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(BANKS*WORDS),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fuse_strobe
);

    localparam int DEPTH  = BANKS * WORDS;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BANK_W = IDX_W - WSEL_W;

    logic [15:0]       unlock_q;
    logic [IDX_W-1:0]  addr_q;
    logic              err_q;
    timing_t           timing_q;
    logic [DATA_W-1:0] data_q;
    op_e               op_q;
    logic [IDX_W-1:0]  op_idx_q;

    logic              busy, seq_last;
    logic [DATA_W-1:0] sh_rdata;
    logic [BANKS-1:0]  lock_bits;
    logic [DATA_W-1:0] ctrl_word;

    logic             wr_en, in_shadow;
    logic [IDX_W-1:0] off;
    logic             hit_ctrl, hit_set, hit_clr, hit_time, hit_sense, hit_data;
    logic             req_sense, key_ok, locked;
    logic             start_sense, start_prog, err_set;
    logic [BANK_W-1:0] cur_bank;

    assign wr_en     = bus_sel && bus_wr;
    assign in_shadow = bus_addr[IDX_W];
    assign off       = bus_addr[IDX_W-1:0];
    assign hit_ctrl  = wr_en && !in_shadow && off == IDX_W'(OFF_CTRL);
    assign hit_set   = wr_en && !in_shadow && off == IDX_W'(OFF_SET);
    assign hit_clr   = wr_en && !in_shadow && off == IDX_W'(OFF_CLR);
    assign hit_time  = wr_en && !in_shadow && off == IDX_W'(OFF_TIME);
    assign hit_sense = wr_en && !in_shadow && off == IDX_W'(OFF_SENSE);
    assign hit_data  = wr_en && !in_shadow && off == IDX_W'(OFF_DATA);

    assign cur_bank    = addr_q[IDX_W-1:WSEL_W];
    assign locked      = lock_bits[cur_bank];
    assign key_ok      = (unlock_q == UNLOCK_KEY);
    assign req_sense   = hit_sense && bus_wdata[0];
    assign start_sense = req_sense && !busy;
    assign start_prog  = hit_data && !busy && key_ok && !locked;
    assign err_set     = ((req_sense || hit_data) && busy)
                       || (hit_data && !busy && (!key_ok || locked));

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_q <= '0;
            addr_q   <= '0;
            err_q    <= 1'b0;
            timing_q <= '0;
            data_q   <= '0;
            op_q     <= OP_SENSE;
            op_idx_q <= '0;
        end else begin
            if (hit_ctrl) begin
                unlock_q <= bus_wdata[31:16];
                addr_q   <= bus_wdata[IDX_W-1:0];
            end
            if (hit_set) begin
                unlock_q <= unlock_q | bus_wdata[31:16];
                addr_q   <= addr_q | bus_wdata[IDX_W-1:0];
            end
            if (hit_clr) begin
                unlock_q <= unlock_q & ~bus_wdata[31:16];
                addr_q   <= addr_q & ~bus_wdata[IDX_W-1:0];
                if (bus_wdata[ERR_BIT])
                    err_q <= 1'b0;
            end
            if (hit_time)
                timing_q <= timing_t'(bus_wdata[21:0]);
            if (err_set)
                err_q <= 1'b1;
            if (start_sense || start_prog) begin
                op_q     <= start_prog ? OP_PROG : OP_SENSE;
                op_idx_q <= addr_q;
            end
            if (start_prog)
                data_q <= bus_wdata;
            if (seq_last && op_q == OP_PROG)
                unlock_q <= '0;
        end
    end

    otpc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_sense || start_prog),
        .span_i   (op_span(timing_q, start_prog ? OP_PROG : OP_SENSE)),
        .guard_i  (op_guard(timing_q)),
        .busy_o   (busy),
        .strobe_o (fuse_strobe),
        .last_o   (seq_last)
    );

    otpc_store #(
        .DEPTH  (DEPTH),
        .DW     (DATA_W),
        .LOCK_W (BANKS)
    ) u_store (
        .clk          (clk),
        .rst          (rst),
        .sh_we        (wr_en && in_shadow),
        .sh_idx       (off),
        .sh_wdata     (bus_wdata),
        .sense_commit (seq_last && op_q == OP_SENSE),
        .prog_commit  (seq_last && op_q == OP_PROG),
        .op_idx       (op_idx_q),
        .prog_data    (data_q),
        .sh_rdata     (sh_rdata),
        .lock_bits    (lock_bits)
    );

    assign ctrl_word = {unlock_q, 6'd0, err_q, busy, {(8-IDX_W){1'b0}}, addr_q};

    always_comb begin
        bus_rdata = '0;
        if (in_shadow)
            bus_rdata = sh_rdata;
        else if (off == IDX_W'(OFF_CTRL) || off == IDX_W'(OFF_SET) || off == IDX_W'(OFF_CLR))
            bus_rdata = ctrl_word;
        else if (off == IDX_W'(OFF_TIME))
            bus_rdata = {10'd0, timing_q};
        else if (off == IDX_W'(OFF_DATA))
            bus_rdata = data_q;
    end

endmodule

// File: rtl/otpc_checker.sv
module otpc_checker
    import otpc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              clr_bit,
    input logic              busy,
    input logic              err,
    input logic [15:0]       unlock,
    input logic              op_prog,
    input logic              fuse_strobe
);

    logic wr_data, wr_sense, wr_clr;
    assign wr_data  = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_DATA);
    assign wr_sense = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_SENSE);
    assign wr_clr   = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_CLR) && clr_bit;

    assert_strobe_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
        fuse_strobe |-> busy);

    assert_busy_from_request_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_sense || wr_data));

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(err) |-> $past(wr_clr));

    assert_key_wiped_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(op_prog)) |-> (unlock == 16'd0));

    assert_nokey_refused_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_data && unlock != UNLOCK_KEY) |=> (err && !busy));

    assert_busy_request_err_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_data) |=> err);

endmodule

bind otp_fuse_ctrl otpc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .clr_bit     (bus_wdata[9]),
    .busy        (busy),
    .err         (err_q),
    .unlock      (unlock_q),
    .op_prog     (op_q == otpc_pkg::OP_PROG),
    .fuse_strobe (fuse_strobe)
);

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        fuse_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit mdl_active = 1'b0;
    int mdl_P = 0;
    int mdl_T = 0;
    int mdl_R = 0;

    otp_fuse_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .fuse_strobe (fuse_strobe)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural model of the busy window and the strobe window, compared every clock
    always begin
        @(posedge clk);
        #5;
        if (!rst) begin
            int  e;
            bit  exp_busy, exp_strobe;
            e          = cyc - mdl_P;
            exp_busy   = mdl_active && e >= 0 && e < mdl_T;
            exp_strobe = exp_busy && e >= mdl_R && e < mdl_T - mdl_R;
            chk(fuse_strobe == exp_strobe, "R5 strobe window", 32'(fuse_strobe), 32'(exp_strobe));
            if (bus_addr == 8'd0)
                chk(bus_rdata[8] == exp_busy, "R4 busy window", 32'(bus_rdata[8]), 32'(exp_busy));
        end
    end

    task automatic wr(input int a, input logic [31:0] d, input int t_len, input int g_len);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = 8'(a);
        bus_wdata = d;
        if (t_len > 0) begin
            mdl_P      = cyc + 1;
            mdl_T      = t_len;
            mdl_R      = g_len;
            mdl_active = 1'b1;
        end
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = 8'd0;
        bus_wdata = 32'd0;
    endtask

    task automatic expect_rd(input int a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        @(negedge clk);
        bus_addr = 8'(a);
        #5;
        v = bus_rdata;
        bus_addr = 8'd0;
        chk(v === exp, req, v, exp);
    endtask

    task automatic wait_op();
        repeat (mdl_T + 2) @(negedge clk);
    endtask

    // timing word: read length 12 (T=13), relax 2 (G=3), program length 20 (T=21)
    localparam logic [31:0] TIMING_STD = 32'h000C_2014;
    localparam int T_RD = 13;
    localparam int T_PG = 21;
    localparam int G_STD = 3;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_rd(0, 32'h0, "R1 ctrl after reset");
        expect_rd(3, 32'h0, "R1 timing after reset");
        expect_rd(8'h85, 32'h0, "R1 shadow after reset");

        // R12 timing fields
        wr(3, 32'hFFFF_FFFF, 0, 0);
        expect_rd(3, 32'h003F_FFFF, "R12 timing width");
        wr(3, TIMING_STD, 0, 0);
        expect_rd(3, TIMING_STD, "R12 timing value");

        // R2 control word and aliases
        wr(0, 32'h1234_0015, 0, 0);
        expect_rd(0, 32'h1234_0015, "R2 ctrl write");
        wr(1, 32'h0001_0008, 0, 0);
        expect_rd(1, 32'h1235_001D, "R2 set alias");
        wr(2, 32'h0235_0005, 0, 0);
        expect_rd(2, 32'h1000_0018, "R2 clear alias");

        // R6 / R11 burn bank 3 word 5 (index 29)
        wr(0, 32'h3E77_001D, 0, 0);
        wr(5, 32'hA5A5_0000, T_PG, G_STD);
        wait_op();
        expect_rd(0, 32'h0000_001D, "R6 key wiped after burn");
        wr(4, 32'h1, T_RD, G_STD);
        wait_op();
        expect_rd(8'h80 + 29, 32'hA5A5_0000, "R4 R11 sensed word 29");
        expect_rd(8'h80 + 28, 32'h0, "R11 neighbour untouched");

        // R6 burning only sets bits
        wr(0, 32'h3E77_001D, 0, 0);
        wr(5, 32'h0000_00FF, T_PG, G_STD);
        wait_op();
        wr(4, 32'h1, T_RD, G_STD);
        wait_op();
        expect_rd(8'h80 + 29, 32'hA5A5_00FF, "R6 OR of old and new");

        // R7 data write without key
        wr(5, 32'hFFFF_FFFF, 0, 0);
        expect_rd(0, 32'h0000_021D, "R7 error set, not busy");
        wr(4, 32'h1, T_RD, G_STD);
        wait_op();
        expect_rd(8'h80 + 29, 32'hA5A5_00FF, "R7 fuse unchanged");

        // R3 sticky error
        wr(0, 32'h0000_021D, 0, 0);
        expect_rd(0, 32'h0000_021D, "R3 ctrl write keeps error");
        wr(1, 32'h0000_0200, 0, 0);
        expect_rd(0, 32'h0000_021D, "R3 set alias keeps error");
        wr(2, 32'h0000_0200, 0, 0);
        expect_rd(0, 32'h0000_001D, "R3 clear alias clears error");

        // R8 request while busy
        wr(0, 32'h0000_0028, 0, 0);
        wr(4, 32'h1, T_RD, G_STD);
        wr(4, 32'h1, 0, 0);
        wr(5, 32'h1, 0, 0);
        wait_op();
        expect_rd(0, 32'h0000_0228, "R8 error after busy request");
        expect_rd(8'h80 + 40, 32'h0, "R8 running sense completed");
        wr(2, 32'h0000_0200, 0, 0);

        // R10 shadow override
        wr(8'h80 + 40, 32'hDEAD_BEEF, 0, 0);
        expect_rd(8'h80 + 40, 32'hDEAD_BEEF, "R10 shadow override");
        wr(4, 32'h1, T_RD, G_STD);
        wait_op();
        expect_rd(8'h80 + 40, 32'h0, "R10 fuse untouched by override");

        // R9 lock bank 2 through fuse word 0 bit 2
        wr(0, 32'h3E77_0000, 0, 0);
        wr(5, 32'h0000_0004, T_PG, G_STD);
        wait_op();
        wr(4, 32'h1, T_RD, G_STD);
        wait_op();
        expect_rd(8'h80, 32'h0000_0004, "R6 lock word burned");
        wr(0, 32'h3E77_0011, 0, 0);
        wr(5, 32'h0000_000F, 0, 0);
        expect_rd(0, 32'h3E77_0211, "R9 locked bank refused");
        wr(2, 32'h3E77_0200, 0, 0);
        wr(4, 32'h1, T_RD, G_STD);
        wait_op();
        expect_rd(8'h80 + 17, 32'h0, "R9 locked word unchanged");

        // R5 guards longer than the duration: no strobe at all
        wr(3, 32'h0005_7014, 0, 0);
        wr(4, 32'h1, 6, 8);
        wait_op();
        expect_rd(0, 32'h0000_0011, "R5 short sense finished");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule